// File: doc/BRIEF.md
# Character Display Controller Command Core

This block is the device-side command engine of a dot-matrix character display controller. A host drives a parallel bus made of a register-select line, a read/write line, eight data lines and a one-cycle strobe. Each strobe is decoded as an instruction, a status readout, a data write or a data read. The core holds an 80-byte display RAM and a 64-byte glyph RAM. One address counter serves both RAMs, and the last address-load instruction decides which RAM it points at. The core also keeps the entry mode, the display, cursor and blink flags, the bus-width, line-count and font flags, and a display shift offset.

Every accepted instruction or data access holds `busy` high for a fixed number of system-clock cycles. That count comes from the ratio of the system clock to the display oscillator: 10 oscillator periods for normal operations and 410 for clear and home. While `busy` is high, the host may only poll the status word. Anything else is dropped and sets a sticky error flag. The control FSM has three states. `ST_IDLE` accepts work. `ST_CLEAR` writes blanks into the display RAM one byte per cycle. `ST_WAIT` counts out the remaining busy time. There are four transitions: IDLE to CLEAR on an accepted clear, IDLE to WAIT on any other accepted operation, CLEAR to WAIT after the last byte has been blanked, and WAIT to IDLE when the timer expires.

Top module: `chardisp_core`

## Requirements
- R1: With rs=0 and rw=0, the highest set bit of `bus_din` selects the instruction: bit0 clear, bit1 home, bit2 entry mode, bit3 display control, bit4 shift, bit5 function set, bit6 glyph address, bit7 display address. Lower bits beyond each instruction's fields are ignored, and a zero byte does nothing and does not make the core busy.
- R2: Clear writes 0x20 into all 80 display RAM bytes, sets the counter to 0, selects the display RAM and sets the shift offset to 0.
- R3: Home sets the counter and the shift offset to 0 and selects the display RAM. It does not change the RAM contents.
- R4: Entry mode takes din[1] as the direction (1 = up) and din[0] as the shift enable. Each data access moves the counter one step in that direction, wrapping modulo 80 for the display RAM and modulo 64 for the glyph RAM.
- R5: When the shift enable is 1, each data access also moves `shift_ofs` one step in the counter's direction, modulo 80.
- R6: The shift instruction (din[4]=1) moves `shift_ofs` when din[3]=1 and moves the counter when din[3]=0. din[2]=1 is +1 and din[2]=0 is -1, with the same wraps as R4 and R5.
- R7: Display control loads `disp_on`, `cursor_on` and `blink_on` from din[2:0]. Function set loads `bus8`, `two_line` and `tall_font` from din[4:2]. After reset these six flags are 0,0,0,1,0,0 and the direction is up with shift off.
- R8: The glyph address instruction loads din[5:0] and selects the glyph RAM. The display address instruction loads din[6:0], minus 80 when that value is 80 or more, and selects the display RAM.
- R9: rs=1, rw=0 writes `bus_din` at the counter. rs=1, rw=1 places the byte at the counter on `bus_dout` one cycle after the strobe. Both then step the counter as in R4.
- R10: rs=0, rw=1 places {busy, counter} on `bus_dout` one cycle after the strobe. This is accepted even while busy and changes no state.
- R11: `busy` rises on the cycle after an accepted operation and stays high for exactly 10·(CLK_HZ/OSC_HZ) cycles, or 410·(CLK_HZ/OSC_HZ) for clear and home.
- R12: An instruction or data access strobed while busy has no effect and sets `err_sticky`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_stb | input | 1 | One-cycle access strobe |
| bus_rs | input | 1 | 0 = instruction/status, 1 = data |
| bus_rw | input | 1 | 1 = read |
| bus_din | input | 8 | Host write byte |
| bus_dout | output | 8 | Registered read byte |
| busy | output | 1 | Operation in progress |
| err_sticky | output | 1 | Access dropped while busy |
| disp_on | output | 1 | Display enabled |
| cursor_on | output | 1 | Cursor shown |
| blink_on | output | 1 | Cursor cell blinks |
| entry_up | output | 1 | Counter direction after access |
| entry_shift | output | 1 | Shift display on access |
| bus8 | output | 1 | 8-bit host bus mode |
| two_line | output | 1 | Two-line layout |
| tall_font | output | 1 | 5x10 font |
| shift_ofs | output | 7 | Display shift offset, 0..79 |

## Verification
The assertions check on every cycle that the counter stays inside the selected RAM and the shift offset stays below 80. They also check that a command strobed while busy latches the error flag, which never clears, that an accepted command raises busy, that a status read returns the prior busy and counter values, and that home zeroes the counter and the offset. The exact busy lengths, the blank fill, address wrapping, the priority decode and readback of stored bytes can only be shown by the bench scenarios. In those scenarios a behavioural model is compared against the outputs on every clock.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_WAIT
    } cd_state_e;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CLEAR,
        OP_HOME,
        OP_ENTRY,
        OP_DISP,
        OP_SHIFT,
        OP_FUNC,
        OP_CGADR,
        OP_DDADR,
        OP_STATUS,
        OP_WRITE,
        OP_READ
    } cd_op_e;

endpackage

// File: rtl/chardisp_decode.sv
module chardisp_decode
    import chardisp_pkg::*;
(
    input  logic       rs,
    input  logic       rw,
    input  logic [7:0] din,
    output cd_op_e     op
);

    // Highest set bit picks the instruction class (R1)
    always_comb begin
        op = OP_NONE;
        unique case ({rs, rw})
            2'b01:   op = OP_STATUS;
            2'b10:   op = OP_WRITE;
            2'b11:   op = OP_READ;
            default: begin
                if      (din[7]) op = OP_DDADR;
                else if (din[6]) op = OP_CGADR;
                else if (din[5]) op = OP_FUNC;
                else if (din[4]) op = OP_SHIFT;
                else if (din[3]) op = OP_DISP;
                else if (din[2]) op = OP_ENTRY;
                else if (din[1]) op = OP_HOME;
                else if (din[0]) op = OP_CLEAR;
                else             op = OP_NONE;
            end
        endcase
    end

endmodule

// File: rtl/chardisp_busy_timer.sv
module chardisp_busy_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - CW'(1);
    end

    assign last = (cnt == CW'(1));

endmodule

// File: rtl/chardisp_core.sv
module chardisp_core
    import chardisp_pkg::*;
#(
    parameter int CLK_HZ   = 125_000_000,
    parameter int OSC_HZ   = 250_000,
    parameter int DD_DEPTH = 80,
    parameter int CG_DEPTH = 64,
    parameter logic [7:0] BLANK = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_stb,
    input  logic       bus_rs,
    input  logic       bus_rw,
    input  logic [7:0] bus_din,
    output logic [7:0] bus_dout,
    output logic       busy,
    output logic       err_sticky,
    output logic       disp_on,
    output logic       cursor_on,
    output logic       blink_on,
    output logic       entry_up,
    output logic       entry_shift,
    output logic       bus8,
    output logic       two_line,
    output logic       tall_font,
    output logic [6:0] shift_ofs
);

    localparam int TICK     = CLK_HZ / OSC_HZ;
    localparam int T_STD    = 10 * TICK;
    localparam int T_LONG   = 410 * TICK;
    localparam int CW       = $clog2(T_LONG + 1);
    localparam logic [6:0] DD_TOP = 7'(DD_DEPTH - 1);
    localparam logic [6:0] CG_TOP = 7'(CG_DEPTH - 1);

    cd_state_e  state, nxt;
    cd_op_e     op;
    logic [6:0] ac;
    logic       sel_cg;
    logic [6:0] fill_idx;
    logic       t_last;
    logic       is_cmd, accept, drop;
    logic [6:0] cur_top, dd_load;
    logic [7:0] dd_mem [DD_DEPTH];
    logic [7:0] cg_mem [CG_DEPTH];

    function automatic logic [6:0] wrap_step(input logic [6:0] a, input logic up,
                                             input logic [6:0] top);
        if (up) return (a == top) ? 7'd0 : a + 7'd1;
        return (a == 7'd0) ? top : a - 7'd1;
    endfunction

    chardisp_decode u_dec (
        .rs  (bus_rs),
        .rw  (bus_rw),
        .din (bus_din),
        .op  (op)
    );

    assign is_cmd = (op != OP_NONE) && (op != OP_STATUS);
    assign accept = bus_stb && is_cmd && (state == ST_IDLE);
    assign drop   = bus_stb && is_cmd && (state != ST_IDLE);
    assign busy   = (state != ST_IDLE);

    chardisp_busy_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val ((op == OP_CLEAR || op == OP_HOME) ? CW'(T_LONG) : CW'(T_STD)),
        .last     (t_last)
    );

    assign cur_top = sel_cg ? CG_TOP : DD_TOP;
    assign dd_load = (bus_din[6:0] >= 7'(DD_DEPTH)) ? bus_din[6:0] - 7'(DD_DEPTH)
                                                    : bus_din[6:0];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (accept) nxt = (op == OP_CLEAR) ? ST_CLEAR : ST_WAIT;
            ST_CLEAR: if (fill_idx == DD_TOP) nxt = ST_WAIT;
            ST_WAIT:  if (t_last) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Datapath and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac <= '0;  sel_cg <= 1'b0;  shift_ofs <= '0;  fill_idx <= '0;
            bus_dout <= '0;  err_sticky <= 1'b0;
            disp_on <= 1'b0;  cursor_on <= 1'b0;  blink_on <= 1'b0;
            entry_up <= 1'b1;  entry_shift <= 1'b0;
            bus8 <= 1'b1;  two_line <= 1'b0;  tall_font <= 1'b0;
        end else begin
            if (state == ST_CLEAR) begin
                dd_mem[fill_idx] <= BLANK;
                fill_idx <= fill_idx + 7'd1;
            end
            if (drop) err_sticky <= 1'b1;
            if (bus_stb && op == OP_STATUS) bus_dout <= {busy, ac};
            if (accept) begin
                unique case (op)
                    OP_CLEAR: begin
                        ac <= '0; sel_cg <= 1'b0; shift_ofs <= '0; fill_idx <= '0;
                    end
                    OP_HOME: begin
                        ac <= '0; sel_cg <= 1'b0; shift_ofs <= '0;
                    end
                    OP_ENTRY: begin
                        entry_up <= bus_din[1]; entry_shift <= bus_din[0];
                    end
                    OP_DISP: begin
                        disp_on <= bus_din[2]; cursor_on <= bus_din[1]; blink_on <= bus_din[0];
                    end
                    OP_SHIFT: begin
                        if (bus_din[3]) shift_ofs <= wrap_step(shift_ofs, bus_din[2], DD_TOP);
                        else            ac <= wrap_step(ac, bus_din[2], cur_top);
                    end
                    OP_FUNC: begin
                        bus8 <= bus_din[4]; two_line <= bus_din[3]; tall_font <= bus_din[2];
                    end
                    OP_CGADR: begin
                        ac <= {1'b0, bus_din[5:0]}; sel_cg <= 1'b1;
                    end
                    OP_DDADR: begin
                        ac <= dd_load; sel_cg <= 1'b0;
                    end
                    OP_WRITE, OP_READ: begin
                        if (op == OP_WRITE) begin
                            if (sel_cg) cg_mem[ac[5:0]] <= bus_din;
                            else        dd_mem[ac]      <= bus_din;
                        end else begin
                            bus_dout <= sel_cg ? cg_mem[ac[5:0]] : dd_mem[ac];
                        end
                        ac <= wrap_step(ac, entry_up, cur_top);
                        if (entry_shift) shift_ofs <= wrap_step(shift_ofs, entry_up, DD_TOP);
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/chardisp_checker.sv
module chardisp_checker #(
    parameter int DD_DEPTH = 80,
    parameter int CG_DEPTH = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_stb,
    input logic       bus_rs,
    input logic       bus_rw,
    input logic [7:0] bus_din,
    input logic [7:0] bus_dout,
    input logic       busy,
    input logic       err_sticky,
    input logic [6:0] ac,
    input logic       sel_cg,
    input logic [6:0] shift_ofs
);

    logic cmd_like, home_cmd;
    assign cmd_like = !(!bus_rs && bus_rw) && !(!bus_rs && !bus_rw && bus_din == 8'h00);
    assign home_cmd = !bus_rs && !bus_rw && (bus_din[7:1] == 7'b0000001);

    p_err_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    p_drop_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && busy && cmd_like) |=> err_sticky);

    p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && !busy && cmd_like) |=> busy);

    p_status_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && !bus_rs && bus_rw) |=> bus_dout == {$past(busy), $past(ac)});

    p_ac_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ac < 7'(DD_DEPTH)) && (!sel_cg || ac < 7'(CG_DEPTH)));

    p_ofs_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_ofs < 7'(DD_DEPTH));

    p_home_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && !busy && home_cmd) |=> (ac == 7'd0 && shift_ofs == 7'd0 && !sel_cg));

endmodule

bind chardisp_core chardisp_checker #(
    .DD_DEPTH (DD_DEPTH),
    .CG_DEPTH (CG_DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_stb    (bus_stb),
    .bus_rs     (bus_rs),
    .bus_rw     (bus_rw),
    .bus_din    (bus_din),
    .bus_dout   (bus_dout),
    .busy       (busy),
    .err_sticky (err_sticky),
    .ac         (ac),
    .sel_cg     (sel_cg),
    .shift_ofs  (shift_ofs)
);

// File: tb/tb_chardisp_core.sv
module tb_chardisp_core;

    localparam int TB_CLK = 1_000_000;
    localparam int TB_OSC = 250_000;
    localparam int E_STD  = 10 * (TB_CLK / TB_OSC);
    localparam int E_LONG = 410 * (TB_CLK / TB_OSC);

    logic clk = 1'b0, rst_n = 1'b0, stb = 1'b0, rs = 1'b0, rw = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic busy, err, d_on, c_on, b_on, e_up, e_sh, b8, tl, tf;
    logic [6:0] ofs;

    always #4 clk = ~clk;

    chardisp_core #(.CLK_HZ(TB_CLK), .OSC_HZ(TB_OSC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_stb(stb), .bus_rs(rs), .bus_rw(rw),
        .bus_din(din), .bus_dout(dout), .busy(busy), .err_sticky(err),
        .disp_on(d_on), .cursor_on(c_on), .blink_on(b_on), .entry_up(e_up),
        .entry_shift(e_sh), .bus8(b8), .two_line(tl), .tall_font(tf),
        .shift_ofs(ofs)
    );

    int n_tests = 0, n_fail = 0;

    task automatic chk(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // Behavioural reference model
    int m_ac, m_sel, m_ofs, m_up, m_sh, m_d, m_c, m_b, m_dl, m_n, m_f;
    int m_left, m_err, m_dout;
    int m_dd [80];
    int m_cg [64];

    function automatic int wrapf(input int v, input int n);
        return ((v % n) + n) % n;
    endfunction

    always @(posedge clk) begin
        int was_busy, dir;
        if (!rst_n) begin
            m_ac = 0; m_sel = 0; m_ofs = 0; m_up = 1; m_sh = 0;
            m_d = 0; m_c = 0; m_b = 0; m_dl = 1; m_n = 0; m_f = 0;
            m_left = 0; m_err = 0; m_dout = 0;
        end else begin
            was_busy = (m_left > 0) ? 1 : 0;
            if (m_left > 0) m_left--;
            if (stb) begin
                if (!rs && rw) m_dout = was_busy * 128 + m_ac;
                else if (!rs && !rw && din == 8'h00) begin end
                else if (was_busy != 0) m_err = 1;
                else begin
                    m_left = E_STD;
                    if (rs) begin
                        if (!rw) begin
                            if (m_sel != 0) m_cg[m_ac] = din; else m_dd[m_ac] = din;
                        end else m_dout = (m_sel != 0) ? m_cg[m_ac] : m_dd[m_ac];
                        dir = (m_up != 0) ? 1 : -1;
                        m_ac = wrapf(m_ac + dir, (m_sel != 0) ? 64 : 80);
                        if (m_sh != 0) m_ofs = wrapf(m_ofs + dir, 80);
                    end else if (din[7]) begin
                        m_sel = 0; m_ac = din[6:0]; if (m_ac >= 80) m_ac -= 80;
                    end else if (din[6]) begin
                        m_sel = 1; m_ac = din[5:0];
                    end else if (din[5]) begin
                        m_dl = din[4]; m_n = din[3]; m_f = din[2];
                    end else if (din[4]) begin
                        dir = din[2] ? 1 : -1;
                        if (din[3]) m_ofs = wrapf(m_ofs + dir, 80);
                        else m_ac = wrapf(m_ac + dir, (m_sel != 0) ? 64 : 80);
                    end else if (din[3]) begin
                        m_d = din[2]; m_c = din[1]; m_b = din[0];
                    end else if (din[2]) begin
                        m_up = din[1]; m_sh = din[0];
                    end else begin
                        if (!din[1]) for (int i = 0; i < 80; i++) m_dd[i] = 8'h20;
                        m_ac = 0; m_sel = 0; m_ofs = 0; m_left = E_LONG;
                    end
                end
            end
        end
    end

    // Compare model against outputs on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R11 busy per cycle", busy, (m_left > 0) ? 1 : 0);
            chk("R12 err per cycle", err, m_err);
            chk("R9 dout per cycle", dout, m_dout);
            chk("R6 ofs per cycle", ofs, m_ofs);
            chk("R7 flags per cycle", {d_on, c_on, b_on, e_up, e_sh, b8, tl, tf},
                m_d*128 + m_c*64 + m_b*32 + m_up*16 + m_sh*8 + m_dl*4 + m_n*2 + m_f);
        end
    end

    task automatic acc(input logic r_s, input logic r_w, input logic [7:0] v);
        @(negedge clk);
        stb = 1'b1; rs = r_s; rw = r_w; din = v;
        @(negedge clk);
        stb = 1'b0; rs = 1'b0; rw = 1'b0; din = 8'h00;
    endtask

    task automatic idle();
        while (busy) @(negedge clk);
    endtask

    task automatic run(input logic r_s, input logic r_w, input logic [7:0] v);
        acc(r_s, r_w, v);
        idle();
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    task automatic status(output int v);
        acc(1'b0, 1'b1, 8'h00);
        v = dout;
    endtask

    initial begin
        #(8 * 150_000);
        n_fail++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset flags", {d_on, c_on, b_on, e_up, e_sh, b8, tl, tf}, 8'h14);
        chk("R11 reset busy", busy, 0);
        chk("R12 reset err", err, 0);

        acc(0, 0, 8'h00);
        chk("R1 zero byte not busy", busy, 0);

        acc(0, 0, 8'h01); busy_len(v);
        chk("R11 clear busy length", v, E_LONG);
        status(v); chk("R10 status after clear", v, 0);
        acc(1, 1, 8'h00); chk("R2 blank byte", dout, 8'h20); idle();
        status(v); chk("R9 counter after read", v, 1);

        run(0, 0, 8'hCF); run(1, 0, 8'h41);
        status(v); chk("R4 display wrap up", v, 0);
        run(0, 0, 8'hCF); acc(1, 1, 8'h00); chk("R9 readback", dout, 8'h41); idle();

        run(0, 0, 8'h04); run(0, 0, 8'h80); run(1, 0, 8'h42);
        status(v); chk("R4 display wrap down", v, 79);
        run(0, 0, 8'hFF); status(v); chk("R8 display address reduce", v, 47);

        run(0, 0, 8'h7F); status(v); chk("R8 glyph address", v, 63);
        run(0, 0, 8'h06); run(1, 0, 8'h1F);
        status(v); chk("R4 glyph wrap", v, 0);
        run(0, 0, 8'h7F); acc(1, 1, 8'h00); chk("R9 glyph readback", dout, 8'h1F); idle();

        run(0, 0, 8'h3F);
        chk("R1 function set priority", {b8, tl, tf}, 3'b111);
        run(0, 0, 8'h0F);
        chk("R7 display control", {d_on, c_on, b_on}, 3'b111);

        run(0, 0, 8'h1C); chk("R6 display right", ofs, 1);
        run(0, 0, 8'h18); run(0, 0, 8'h18); chk("R6 display left wrap", ofs, 79);
        run(0, 0, 8'h85); run(0, 0, 8'h14);
        status(v); chk("R6 cursor right", v, 6);
        run(0, 0, 8'h10); status(v); chk("R6 cursor left", v, 5);

        run(0, 0, 8'h07); run(1, 0, 8'h55);
        chk("R5 entry shift wrap", ofs, 0);

        run(0, 0, 8'h1C); run(0, 0, 8'h02);
        chk("R3 home offset", ofs, 0);
        status(v); chk("R3 home counter", v, 0);
        run(0, 0, 8'h06); run(0, 0, 8'hCF);
        acc(1, 1, 8'h00); chk("R3 contents kept", dout, 8'h41); idle();

        acc(0, 0, 8'h0C); acc(0, 0, 8'h08);
        chk("R12 dropped command", d_on, 1);
        chk("R12 err set", err, 1);
        status(v); chk("R10 busy bit while busy", v / 128, 1);
        idle();

        acc(0, 0, 8'h06); busy_len(v);
        chk("R11 standard busy length", v, E_STD);
        chk("R12 err stays", err, 1);

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule